// File: doc/BRIEF.md
# Addressable Bit Register with Decoder Mode

This block stores one bit per output line and has a binary address, a single data line and two active-low controls. The two controls together select one of four modes. In the first, the addressed bit is updated from the data line. In the second, every bit is held. In the third, the data line is routed to exactly one output and every other output is driven low, so the block works as a demultiplexer or, with data tied high, as an active-high one-hot decoder. In the fourth, every bit is cleared.

The storage is a bank of clocked flip-flops rather than level-sensitive latches. Each output is the combinational next-state value of its flip-flop. A written bit therefore shows the new data in the same cycle it is presented, and the flip-flop captures it at the following rising clock edge. The value that remains once the enable returns high is the data of the last clock cycle in which the enable was low.

A separate asynchronous power-on reset zeroes the storage. The output count is a power-of-two parameter, and the address width is derived from it. Every control and data pin is a plain level signal; the block has no streaming handshake.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst_n` is low, every stored bit is zero, so with `le_n`=1 and `clr_n`=1 every output reads 0, including when reset is applied in the middle of operation.
- R2: The modes are decoded as follows: (`le_n`,`clr_n`)=(0,1) is write, (1,1) is hold, (0,0) is demux and (1,0) is clear.
- R3: In write mode, output `q[addr]` equals `din` in the same cycle, and every other output keeps its value from the previous cycle.
- R4: In hold mode, every output keeps its previous value whatever `addr` and `din` do.
- R5: In demux mode, `q[addr]` equals `din` and every other output is 0.
- R6: In clear mode, every output is 0 whatever `addr` and `din` do.
- R7: After `le_n` rises with `clr_n` high, the addressed bit keeps the `din` value of the last cycle in which `le_n` was low, even if `din` changed on every cycle of the write.
- R8: Leaving demux mode for hold mode leaves the stored pattern equal to the last demux output: only the last addressed bit can be 1.
- R9: The address is unsigned binary with bit 0 least significant, and value k selects `q[k]`. With `din`=1 in demux mode, sweeping k from 0 to N-1 gives `q` = 1<<k.
- R10: N must be a power of two, and the address width is log2(N).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the storage |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| le_n | input | 1 | Enable, active low |
| clr_n | input | 1 | Functional clear, active low |
| addr | input | log2(N) | Bit select, binary |
| din | input | 1 | Data bit |
| q | output | N | Stored bits or routed data, active high |

## Verification
The assertions assume that `addr`, `din`, `le_n` and `clr_n` settle once per cycle and stay stable across the rising edge. Under that assumption the sampled model cannot see the transient wrong-address write that multi-bit address changes cause in a level-sensitive part. The bench changes every input only at the falling clock edge and reads the outputs one nanosecond later. This keeps the assumption true, so changing several address bits at once, even in write mode, cannot corrupt a non-addressed bit. The hold-type assertions compare against the previous cycle only once reset has been released for at least one edge, so the cycle that follows an asynchronous reset is not checked against a pre-reset value.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import alatch_pkg::*;
(
  input  logic  le_n,
  input  logic  clr_n,
  output mode_e mode
);
  // R2: the two active-low controls select one of four modes
  always_comb begin
    unique case ({le_n, clr_n})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/alatch_addr_dec.sv
module alatch_addr_dec #(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  sel
);
  // R9: binary address, bit 0 least significant
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel[i] = (addr == AW'(i));
  end
endmodule

// File: rtl/alatch_cell.sv
module alatch_cell
  import alatch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  sel,
  input  logic  din,
  output logic  q_o
);
  logic st;
  logic nxt;

  always_comb begin
    unique case (mode)
      MODE_WRITE: nxt = sel ? din : st;
      MODE_HOLD:  nxt = st;
      MODE_DEMUX: nxt = sel & din;
      default:    nxt = 1'b0;
    endcase
  end

  // The output is transparent: it shows the value the flop will capture
  assign q_o = nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= 1'b0;
    else        st <= nxt;
  end

  p_unsel_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode == MODE_WRITE && !sel) |-> (q_o == $past(q_o)));

  p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode == MODE_HOLD) |-> (q_o == $past(q_o)));

  p_rise_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == MODE_WRITE && $past(sel) && mode == MODE_HOLD)
      |-> (q_o == $past(din)));
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import alatch_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 le_n,
  input  logic                 clr_n,
  input  logic [$clog2(N)-1:0] addr,
  input  logic                 din,
  output logic [N-1:0]         q
);
  localparam int AW = $clog2(N);

  mode_e        mode;
  logic [N-1:0] sel;

  alatch_mode_dec u_mode (
    .le_n  (le_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  alatch_addr_dec #(.N(N), .AW(AW)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar i = 0; i < N; i++) begin : g_bit
    alatch_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .sel   (sel[i]),
      .din   (din),
      .q_o   (q[i])
    );
  end

  // R10: the output count must be a power of two
  initial begin
    p_pow2_r10: assert (N == (1 << AW));
  end

  p_addr_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE) |-> (q[addr] == din));

  p_demux_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEMUX) |-> ($onehot0(q) && q[addr] == din));

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |-> (q == '0));

  p_demux_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == MODE_DEMUX && mode == MODE_HOLD)
      |-> ($countones(q) <= 1));
endmodule

// File: tb/addr_latch_demux_bench.sv
module addr_latch_demux_bench;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le_n = 1'b1;
  logic       clr_n = 1'b1;
  logic [2:0] addr = 3'd0;
  logic       din = 1'b0;
  logic [7:0] q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_latch_demux #(.N(N)) u_addr_latch_demux (
    .clk(clk), .rst_n(rst_n), .le_n(le_n), .clr_n(clr_n),
    .addr(addr), .din(din), .q(q)
  );

  // Row format: {le_n, clr_n, addr[2:0], din, expected q[7:0]}
  localparam int NV = 21;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b1, 3'd0, 1'b1, 8'h00},  // R4 hold after reset
    {1'b0, 1'b1, 3'd3, 1'b1, 8'h08},  // R3 write
    {1'b0, 1'b1, 3'd3, 1'b0, 8'h00},  // R3 transparent
    {1'b0, 1'b1, 3'd3, 1'b1, 8'h08},  // R3
    {1'b0, 1'b1, 3'd0, 1'b1, 8'h09},  // R3 other bits kept
    {1'b0, 1'b1, 3'd7, 1'b1, 8'h89},  // R9 top address
    {1'b1, 1'b1, 3'd5, 1'b1, 8'h89},  // R4 ignores inputs
    {1'b1, 1'b1, 3'd2, 1'b0, 8'h89},  // R4
    {1'b0, 1'b1, 3'd7, 1'b0, 8'h09},  // R3
    {1'b1, 1'b1, 3'd1, 1'b1, 8'h09},  // R4
    {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},  // R5 demux
    {1'b0, 1'b0, 3'd6, 1'b1, 8'h40},  // R5
    {1'b0, 1'b0, 3'd6, 1'b0, 8'h00},  // R5 data low
    {1'b0, 1'b0, 3'd5, 1'b1, 8'h20},  // R5
    {1'b1, 1'b1, 3'd0, 1'b0, 8'h20},  // R8 leaves only last bit
    {1'b0, 1'b1, 3'd1, 1'b1, 8'h22},  // R8 others still zero
    {1'b1, 1'b0, 3'd1, 1'b1, 8'h00},  // R6 clear
    {1'b1, 1'b1, 3'd3, 1'b1, 8'h00},  // R6 clear stored
    {1'b0, 1'b1, 3'd4, 1'b1, 8'h10},  // R2 write after clear
    {1'b0, 1'b1, 3'd2, 1'b1, 8'h14},  // R3
    {1'b1, 1'b0, 3'd0, 1'b0, 8'h00}   // R6
  };

  task automatic check(input string req, input logic [7:0] exp);
    n_run++;
    if (q !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%h expected %h", req, q, exp);
    end
  endtask

  task automatic apply(input logic l, input logic c, input logic [2:0] a, input logic d);
    @(negedge clk);
    le_n = l; clr_n = c; addr = a; din = d;
    #1;
  endtask

  initial begin
    #1;
    check("R1", 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      check($sformatf("R2 row %0d", i), VEC[i][7:0]);
    end

    // R9: decoder sweep in demux mode
    for (int k = 0; k < N; k++) begin
      apply(1'b0, 1'b0, 3'(k), 1'b1);
      check("R9", 8'(1 << k));
    end
    apply(1'b1, 1'b0, 3'd0, 1'b0);
    check("R6", 8'h00);

    // R7: din toggles during the write; the last value is kept
    apply(1'b0, 1'b1, 3'd6, 1'b1);
    apply(1'b0, 1'b1, 3'd6, 1'b0);
    apply(1'b0, 1'b1, 3'd6, 1'b1);
    apply(1'b1, 1'b1, 3'd1, 1'b0);
    check("R7 last one", 8'h40);
    apply(1'b0, 1'b1, 3'd6, 1'b0);
    apply(1'b1, 1'b1, 3'd6, 1'b1);
    check("R7 last zero", 8'h00);

    // R1: reset in the middle of operation
    apply(1'b0, 1'b1, 3'd5, 1'b1);
    apply(1'b1, 1'b1, 3'd0, 1'b0);
    check("R4 before reset", 8'h20);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 after release", 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule